// File: doc/BRIEF.md
# Constant Off-Time PWM Current Controller

This block regulates phase current in a three-phase bridge by holding the bridge off for a fixed time whenever current reaches its limit, rather than switching at a fixed frequency. A comparator result, already registered into the clock domain, is high when the sense-resistor voltage is above the reference. While the bridge conducts, the block keeps the low-side switch of the selected leg on. When a valid trip arrives, it runs a slow-decay off sequence. First it waits one dead time with both switches of the leg off. Then it turns the same leg's high-side switch on as a synchronous rectifier. When the off timer expires, it turns that switch off and waits a second dead time before the low side conducts again.

Two guards stop a turn-on spike from shortening the on interval. A blanking window after each turn-on discards the comparator completely. A minimum on time then delays any trip until enough on cycles have passed. All intervals are parameters in clock cycles. Clearing the enable input parks the block in an idle state with every switch request low. Setting it again restarts the cycle with a fresh blanking window. The leg selection comes from the commutation logic as a one-hot vector.

Top module: `cot_pwm_ctrl`

## Requirements
- R1: While rst_ni is low, and after reset while en_i stays low, every bit of lo_en_o and sr_en_o is 0.
- R2: One cycle after en_i is sampled high from idle, lo_en_o equals lo_sel_i (one-hot, bit p = phase p), and sr_en_o stays 0.
- R3: For the first T_BLANK on cycles after every turn-on, trip_i has no effect on the outputs, including a trip in the last blanking cycle.
- R4: The low side stays on for at least T_MIN_ON cycles. A trip held from turn-on gives exactly T_MIN_ON on cycles. A trip pulse before on cycle T_MIN_ON (counting from 1) is dropped and not remembered.
- R5: Once the minimum on time is met, a trip sampled high in on cycle k (counting from 1) ends the on interval after exactly k cycles.
- R6: After the low side turns off, both outputs stay 0 for exactly T_DT cycles. Then sr_en_o takes the value of lo_sel_i.
- R7: sr_en_o stays asserted for exactly T_OFF - T_DT cycles.
- R8: After sr_en_o drops, both outputs stay 0 for exactly T_DT cycles before lo_en_o returns. The low side is therefore off for T_OFF + T_DT cycles in total.
- R9: lo_en_o and sr_en_o are never nonzero in the same cycle.
- R10: One cycle after en_i is sampled low, from any state, both outputs are 0. On re-enable the block starts again with a blanking window.
- R11: trip_i has no effect during the off sequence. A trip held through the off time neither extends nor restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces idle |
| trip_i | input | 1 | Registered comparator: sense above reference |
| lo_sel_i | input | NUM_PH | One-hot leg currently driven low by commutation |
| lo_en_o | output | NUM_PH | Low-side switch requests |
| sr_en_o | output | NUM_PH | High-side synchronous-rectifier requests |

## Verification
The on-interval length is measured against a trip input that is either held from a chosen on cycle or pulsed in one cycle. Pulse positions are placed inside blanking, at its last cycle, between blanking and the minimum-on point, exactly at that point and beyond it. Together they separate a blanking fault, a minimum-on fault and an off-by-one in trip acceptance. Each period also times both dead-time gaps and the rectifier interval, with the trip either released or held through the off sequence, so a retrigger during off shows up as a wrong gap or rectifier length. Enable is dropped once during conduction and once during rectification, then restored with the trip already high, to show the idle path and a restart that begins with blanking.

// File: rtl/cot_pwm_pkg.sv
package cot_pwm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON_BLANK,
    ST_ON,
    ST_OFF_DT1,
    ST_OFF_SYNC,
    ST_OFF_DT2
  } cot_state_e;
endpackage

// File: rtl/cot_seq.sv
module cot_seq
  import cot_pwm_pkg::*;
#(
  parameter int T_BLANK  = 50,
  parameter int T_MIN_ON = 75,
  parameter int T_DT     = 50,
  parameter int T_OFF    = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       trip_i,
  output cot_state_e state_o
);
  localparam int SYNC_LEN = T_OFF - T_DT;
  localparam int MAX_A    = (T_OFF > T_MIN_ON) ? T_OFF : T_MIN_ON;
  localparam int MAX_B    = (T_BLANK > T_DT) ? T_BLANK : T_DT;
  localparam int CNT_MAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] BLANK_END = CW'(T_BLANK - 1);
  localparam logic [CW-1:0] MINON_END = CW'(T_MIN_ON - 1);
  localparam logic [CW-1:0] DT_END    = CW'(T_DT - 1);
  localparam logic [CW-1:0] SYNC_END  = CW'(SYNC_LEN - 1);
  localparam logic [CW-1:0] CNT_SAT   = CW'(CNT_MAX);

  cot_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q;
  logic            cnt_clr;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        st_d    = ST_ON_BLANK;
        cnt_clr = 1'b1;
      end
      // counter keeps running into ST_ON so it measures total on time
      ST_ON_BLANK: if (cnt_q == BLANK_END) st_d = ST_ON;
      ST_ON: if (trip_i && cnt_q >= MINON_END) begin
        st_d    = ST_OFF_DT1;
        cnt_clr = 1'b1;
      end
      ST_OFF_DT1: if (cnt_q == DT_END) begin
        st_d    = ST_OFF_SYNC;
        cnt_clr = 1'b1;
      end
      ST_OFF_SYNC: if (cnt_q == SYNC_END) begin
        st_d    = ST_OFF_DT2;
        cnt_clr = 1'b1;
      end
      ST_OFF_DT2: if (cnt_q == DT_END) begin
        st_d    = ST_ON_BLANK;
        cnt_clr = 1'b1;
      end
      default: begin
        st_d    = ST_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
    if (!en_i) begin
      st_d    = ST_IDLE;
      cnt_clr = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_clr)              cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/cot_leg_drv.sv
module cot_leg_drv
  import cot_pwm_pkg::*;
#(
  parameter int NUM_PH = 3
) (
  input  cot_state_e        state_i,
  input  logic [NUM_PH-1:0] lo_sel_i,
  output logic [NUM_PH-1:0] lo_en_o,
  output logic [NUM_PH-1:0] sr_en_o
);
  logic on_phase, sync_phase;

  assign on_phase   = (state_i == ST_ON_BLANK) || (state_i == ST_ON);
  assign sync_phase = (state_i == ST_OFF_SYNC);

  for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
    assign lo_en_o[p] = lo_sel_i[p] & on_phase;
    assign sr_en_o[p] = lo_sel_i[p] & sync_phase;
  end
endmodule

// File: rtl/cot_pwm_ctrl.sv
module cot_pwm_ctrl
  import cot_pwm_pkg::*;
#(
  parameter int NUM_PH   = 3,
  parameter int T_BLANK  = 50,
  parameter int T_MIN_ON = 75,
  parameter int T_DT     = 50,
  parameter int T_OFF    = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              trip_i,
  input  logic [NUM_PH-1:0] lo_sel_i,
  output logic [NUM_PH-1:0] lo_en_o,
  output logic [NUM_PH-1:0] sr_en_o
);
  cot_state_e state;

  cot_seq #(
    .T_BLANK (T_BLANK),
    .T_MIN_ON(T_MIN_ON),
    .T_DT    (T_DT),
    .T_OFF   (T_OFF)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .trip_i (trip_i),
    .state_o(state)
  );

  cot_leg_drv #(
    .NUM_PH(NUM_PH)
  ) u_leg (
    .state_i (state),
    .lo_sel_i(lo_sel_i),
    .lo_en_o (lo_en_o),
    .sr_en_o (sr_en_o)
  );
endmodule

// File: rtl/cot_pwm_ctrl_chk.sv
module cot_pwm_ctrl_chk #(
  parameter int NUM_PH   = 3,
  parameter int T_BLANK  = 50,
  parameter int T_MIN_ON = 75,
  parameter int T_DT     = 50,
  parameter int T_OFF    = 300
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              trip_i,
  input logic [NUM_PH-1:0] lo_en_o,
  input logic [NUM_PH-1:0] sr_en_o
);
  localparam int MAX_A   = (T_OFF > T_MIN_ON) ? T_OFF : T_MIN_ON;
  localparam int MAX_B   = (T_BLANK > T_DT) ? T_BLANK : T_DT;
  localparam int CNT_MAX = ((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SAT = CW'(CNT_MAX);

  logic          en_q, from_sr_q;
  logic [CW-1:0] gap_q, lo_run_q, sr_run_q;
  logic          any_lo, any_sr;

  assign any_lo = |lo_en_o;
  assign any_sr = |sr_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      from_sr_q <= 1'b0;
      gap_q     <= '0;
      lo_run_q  <= '0;
      sr_run_q  <= '0;
    end else begin
      en_q <= en_i;
      if (any_lo || any_sr) gap_q <= '0;
      else if (gap_q != SAT) gap_q <= gap_q + 1'b1;
      if (!any_lo) lo_run_q <= '0;
      else if (lo_run_q != SAT) lo_run_q <= lo_run_q + 1'b1;
      if (!any_sr) sr_run_q <= '0;
      else if (sr_run_q != SAT) sr_run_q <= sr_run_q + 1'b1;
      if (!en_i || any_lo) from_sr_q <= 1'b0;
      else if (any_sr)     from_sr_q <= 1'b1;
    end
  end

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(any_lo && any_sr));

  p_idle_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (lo_en_o == '0 && sr_en_o == '0));

  p_min_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(any_lo) && en_q) |-> (lo_run_q >= CW'(T_MIN_ON)));

  p_trip_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(any_lo) && en_q) |-> $past(trip_i));

  p_dead_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_sr) |-> (gap_q == CW'(T_DT)));

  p_sync_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(any_sr) && en_q) |-> (sr_run_q == CW'(T_OFF - T_DT)));

  p_dead_trail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(any_lo) && from_sr_q) |-> (gap_q == CW'(T_DT)));
endmodule

bind cot_pwm_ctrl cot_pwm_ctrl_chk #(
  .NUM_PH  (NUM_PH),
  .T_BLANK (T_BLANK),
  .T_MIN_ON(T_MIN_ON),
  .T_DT    (T_DT),
  .T_OFF   (T_OFF)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .trip_i (trip_i),
  .lo_en_o(lo_en_o),
  .sr_en_o(sr_en_o)
);

// File: tb/cot_pwm_ctrl_tb.sv
module cot_pwm_ctrl_tb;
  localparam int NUM_PH   = 3;
  localparam int T_BLANK  = 50;
  localparam int T_MIN_ON = 75;
  localparam int T_DT     = 50;
  localparam int T_OFF    = 300;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic              trip_i = 1'b0;
  logic [NUM_PH-1:0] lo_sel_i = 3'b001;
  logic [NUM_PH-1:0] lo_en_o, sr_en_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #10 clk_i = ~clk_i;

  cot_pwm_ctrl #(
    .NUM_PH(NUM_PH), .T_BLANK(T_BLANK), .T_MIN_ON(T_MIN_ON),
    .T_DT(T_DT), .T_OFF(T_OFF)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .trip_i(trip_i),
    .lo_sel_i(lo_sel_i), .lo_en_o(lo_en_o), .sr_en_o(sr_en_o)
  );

  // pulse: on-cycle index (from 0) of a one-cycle trip, -1 none
  // hold:  on-cycle index from which trip stays high, -1 none
  typedef struct packed {
    int   pulse;
    int   hold;
    logic off_trip;
    int   exp_on;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{10,             120,           1'b0, 121},        // R3 pulse in blanking
    '{-1,             0,             1'b0, T_MIN_ON},   // R4 held from turn-on
    '{60,             150,           1'b0, 151},        // R4 pulse dropped
    '{T_MIN_ON - 1,   -1,            1'b0, T_MIN_ON},   // R5 first legal cycle
    '{T_BLANK - 1,    90,            1'b0, 91},         // R3 last blanking cycle
    '{200,            -1,            1'b1, 201},        // R5 late pulse, R11
    '{-1,             80,            1'b1, 81},         // R5 held, R11
    '{T_BLANK,        T_MIN_ON + 1,  1'b0, T_MIN_ON + 2} // R4 right after blanking
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // entered at a negedge where the low side has just turned on
  task automatic run_period(input int pulse, input int hold, input logic off_trip,
                            input int exp_on, input logic [NUM_PH-1:0] leg);
    int on_n = 0;
    int g1 = 0;
    int s = 0;
    int g2 = 0;
    bit ov = 0;
    check(lo_en_o == leg, "R2 low-side leg", int'(lo_en_o), int'(leg));
    while (lo_en_o != '0) begin
      trip_i = (on_n == pulse) || (hold >= 0 && on_n >= hold);
      if ((lo_en_o & sr_en_o) != '0) ov = 1;
      on_n++;
      @(negedge clk_i);
    end
    check(on_n == exp_on, "R3 R4 R5 on length", on_n, exp_on);
    trip_i = off_trip;
    while (lo_en_o == '0 && sr_en_o == '0) begin g1++; @(negedge clk_i); end
    check(g1 == T_DT, "R6 leading dead time", g1, T_DT);
    check(sr_en_o == leg, "R6 rectifier leg", int'(sr_en_o), int'(leg));
    while (sr_en_o != '0) begin
      if (lo_en_o != '0) ov = 1;
      s++;
      @(negedge clk_i);
    end
    check(s == T_OFF - T_DT, "R7 R11 rectifier length", s, T_OFF - T_DT);
    while (lo_en_o == '0 && sr_en_o == '0) begin g2++; @(negedge clk_i); end
    check(g2 == T_DT, "R8 trailing dead time", g2, T_DT);
    check(g1 + s + g2 == T_OFF + T_DT, "R8 R11 total off", g1 + s + g2, T_OFF + T_DT);
    check(!ov, "R9 overlap", int'(ov), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset and idle
    repeat (3) @(negedge clk_i);
    check(lo_en_o == '0 && sr_en_o == '0, "R1 in reset", int'({lo_en_o, sr_en_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(lo_en_o == '0 && sr_en_o == '0, "R1 idle after reset", int'({lo_en_o, sr_en_o}), 0);

    en_i = 1'b1;
    @(negedge clk_i);
    for (int v = 0; v < NV; v++)
      run_period(VEC[v].pulse, VEC[v].hold, VEC[v].off_trip, VEC[v].exp_on, 3'b001);

    // R10: disable during conduction
    trip_i = 1'b0;
    repeat (20) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check(lo_en_o == '0 && sr_en_o == '0, "R10 off after disable", int'({lo_en_o, sr_en_o}), 0);
    repeat (5) @(negedge clk_i);
    check(lo_en_o == '0 && sr_en_o == '0, "R10 stays idle", int'({lo_en_o, sr_en_o}), 0);

    // R10 R3: re-enable with trip already high restarts with blanking
    lo_sel_i = 3'b010;
    trip_i = 1'b1;
    en_i = 1'b1;
    @(negedge clk_i);
    run_period(-1, 0, 1'b0, T_MIN_ON, 3'b010);

    // R10: disable during synchronous rectification
    trip_i = 1'b1;
    while (lo_en_o != '0) @(negedge clk_i);
    trip_i = 1'b0;
    while (sr_en_o == '0) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check(lo_en_o == '0 && sr_en_o == '0, "R10 off from rectify", int'({lo_en_o, sr_en_o}), 0);
    en_i = 1'b1;
    @(negedge clk_i);
    check(lo_en_o == 3'b010 && sr_en_o == '0, "R10 restart low side", int'(lo_en_o), 2);

    // R1: asynchronous reset during conduction
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(lo_en_o == '0 && sr_en_o == '0, "R1 async reset", int'({lo_en_o, sr_en_o}), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule